// File: doc/BRIEF.md
# Processor Interrupt Pending Controller

This block keeps the eight-line interrupt-pending vector of a processor core and decides whether the core should take an interrupt. Software or neighbouring logic issues one command per cycle: set a line, drop a line, or wipe the whole vector. A line index that names no real line is refused, and a one-cycle error pulse reports it.

A 32-bit counter advances on every clock. It is compared with a software-written compare register. When the two agree and the counter is not zero, the pending line chosen by a 3-bit timer-line field is raised. Writing the compare register acknowledges the timer by dropping that same line.

The core sees three things: the vector itself, a raw flag that is set whenever any line is pending, and a request that is qualified by the status word. The status word carries a per-line mask, a global enable, an exception-level flag and an error-level flag.

Top module: `irq_pend_ctrl`

## Requirements
- R1: Synchronous active-high reset clears the pending vector, the error pulse, the counter and the compare register. `irq_req` and `pend_any` are therefore 0 after reset.
- R2: `cmd_op` is encoded as 0 idle, 1 post, 2 clear and 3 clear-all. A post on line n (0..7) sets `pend_vec[n]` at the next clock edge. A clear on line n drops that bit. A clear-all zeroes the vector, whatever `cmd_line` holds.
- R3: A post or a clear whose `cmd_line` is 8..15 leaves the vector untouched by that command. `cmd_err` is then 1 for exactly the following cycle. At all other times `cmd_err` is 0.
- R4: `irq_req` is 1 only when all of these hold: `stat_gie` is 1, `stat_exl` is 0, `stat_erl` is 0, and `stat_mask & pend_vec` is nonzero. The request is combinational in the current inputs and the current vector.
- R5: Mask bit i gates pending bit i and no other bit. A mask that does not cover any pending bit yields no request.
- R6: The counter is 0 in the first cycle after reset and increases by one each clock. A timer match occurs in a cycle when the counter equals the compare register and the counter is not zero. A compare value of 0 therefore never matches.
- R7: A timer match sets `pend_vec[tmr_line]` at the next edge.
- R8: `pend_any` is 1 exactly when some pending bit is set, regardless of the mask, the enable and the level flags.
- R9: A cycle with `cmp_we` high loads `cmp_wdata` into the compare register. At the same edge it drops `pend_vec[tmr_line]`.
- R10: When a set and a drop hit the same bit in the same cycle, the set wins. The sets are a post and a timer match. The drops are a clear command and a compare write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_op | input | 2 | Command: 0 idle, 1 post, 2 clear, 3 clear-all |
| cmd_line | input | 4 | Line index for post and clear; 8..15 are invalid |
| stat_mask | input | 8 | Per-line interrupt mask from the status word |
| stat_gie | input | 1 | Global interrupt enable |
| stat_exl | input | 1 | Exception-level flag; 1 inhibits requests |
| stat_erl | input | 1 | Error-level flag; 1 inhibits requests |
| tmr_line | input | 3 | Pending line that the timer raises and a compare write drops |
| cmp_we | input | 1 | Compare register write strobe |
| cmp_wdata | input | 32 | Compare register write data |
| pend_vec | output | 8 | Pending vector |
| pend_any | output | 1 | Some line is pending |
| irq_req | output | 1 | Qualified interrupt request to the core |
| cmd_err | output | 1 | One-cycle pulse after an out-of-range post or clear |

## Verification
The vector is a port, so a wrongly set or dropped pending bit shows on `pend_vec` one cycle after the command that caused it. The bench compares that port against its model on every clock. Faults in the counter or the compare register stay hidden until a match is due. They then appear as a missing or early raise of the timer line, or as a spurious raise in the first cycle after reset if the zero exclusion is lost. The qualification path is purely combinational, so a wrong gate shows on `irq_req` in the very cycle the status inputs change.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int NUM_LINES = 8;
    localparam int LINE_W    = $clog2(NUM_LINES);
    localparam int IDX_W     = LINE_W + 1;
    localparam int CNT_W     = 32;

    typedef enum logic [1:0] {
        OP_IDLE      = 2'd0,
        OP_POST      = 2'd1,
        OP_CLEAR     = 2'd2,
        OP_CLEAR_ALL = 2'd3
    } cmd_op_e;

    typedef logic [NUM_LINES-1:0] line_vec_t;

    // Per-cycle update requested of the pending register
    typedef struct packed {
        line_vec_t set_m;
        line_vec_t clr_m;
        logic      bad;
    } upd_t;

    // Qualification fields of the status word
    typedef struct packed {
        line_vec_t mask;
        logic      gie;
        logic      exl;
        logic      erl;
    } stat_t;

    function automatic line_vec_t line_onehot(input logic [LINE_W-1:0] idx);
        line_vec_t v;
        v = '0;
        v[idx] = 1'b1;
        return v;
    endfunction

    function automatic logic idx_valid(input logic [IDX_W-1:0] idx);
        return idx < IDX_W'(NUM_LINES);
    endfunction

endpackage

// File: rtl/irq_cmd_decode.sv
module irq_cmd_decode
    import irq_pkg::*;
#(
    parameter int N  = NUM_LINES,
    parameter int IW = IDX_W
) (
    input  cmd_op_e          op,
    input  logic [IW-1:0]    idx,
    output logic [N-1:0]     set_m,
    output logic [N-1:0]     clr_m,
    output logic             bad
);
    logic in_range;
    logic is_post;
    logic is_clear;
    logic is_all;

    assign in_range = idx < IW'(N);
    assign is_post  = (op == OP_POST);
    assign is_clear = (op == OP_CLEAR);
    assign is_all   = (op == OP_CLEAR_ALL);
    assign bad      = (is_post || is_clear) && !in_range;

    for (genvar g = 0; g < N; g++) begin : g_line
        logic hit;
        assign hit      = in_range && (idx == IW'(g));
        assign set_m[g] = is_post && hit;
        assign clr_m[g] = is_all || (is_clear && hit);
    end

endmodule

// File: rtl/irq_timer.sv
module irq_timer
    import irq_pkg::*;
#(
    parameter int N  = NUM_LINES,
    parameter int LW = LINE_W,
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmp_we,
    input  logic [CW-1:0] cmp_wdata,
    input  logic [LW-1:0] sel,
    output logic          hit,
    output logic [N-1:0]  hit_m,
    output logic [N-1:0]  wclr_m,
    output logic [CW-1:0] count
);
    logic [CW-1:0] count_q;
    logic [CW-1:0] cmp_q;
    logic [N-1:0]  sel_oh;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            cmp_q   <= '0;
        end else begin
            count_q <= count_q + CW'(1);
            if (cmp_we) begin
                cmp_q <= cmp_wdata;
            end
        end
    end

    assign hit   = (count_q == cmp_q) && (count_q != '0);
    assign count = count_q;

    for (genvar g = 0; g < N; g++) begin : g_sel
        assign sel_oh[g] = (sel == LW'(g));
    end

    assign hit_m  = hit    ? sel_oh : '0;
    assign wclr_m = cmp_we ? sel_oh : '0;

endmodule

// File: rtl/irq_pend_reg.sv
module irq_pend_reg
    import irq_pkg::*;
#(
    parameter int N = NUM_LINES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_m,
    input  logic [N-1:0] clr_m,
    input  logic         bad,
    output logic [N-1:0] pend,
    output logic         err
);
    logic [N-1:0] pend_q;
    logic         err_q;

    for (genvar g = 0; g < N; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                pend_q[g] <= 1'b0;
            end else if (set_m[g]) begin
                pend_q[g] <= 1'b1;
            end else if (clr_m[g]) begin
                pend_q[g] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= 1'b0;
        end else begin
            err_q <= bad;
        end
    end

    assign pend = pend_q;
    assign err  = err_q;

endmodule

// File: rtl/irq_qualify.sv
module irq_qualify
    import irq_pkg::*;
(
    input  stat_t     stat,
    input  line_vec_t pend,
    output logic      req,
    output logic      any
);
    logic open_gate;
    logic unmasked;

    assign open_gate = stat.gie && !stat.exl && !stat.erl;
    assign unmasked  = |(stat.mask & pend);
    assign req       = open_gate && unmasked;
    assign any       = |pend;

endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl
    import irq_pkg::*;
#(
    parameter int N  = NUM_LINES,
    parameter int LW = LINE_W,
    parameter int IW = IDX_W,
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    cmd_op,
    input  logic [IW-1:0] cmd_line,
    input  logic [N-1:0]  stat_mask,
    input  logic          stat_gie,
    input  logic          stat_exl,
    input  logic          stat_erl,
    input  logic [LW-1:0] tmr_line,
    input  logic          cmp_we,
    input  logic [CW-1:0] cmp_wdata,
    output logic [N-1:0]  pend_vec,
    output logic          pend_any,
    output logic          irq_req,
    output logic          cmd_err
);
    upd_t          cmd_upd;
    logic          tmr_hit;
    logic [N-1:0]  tmr_set_m;
    logic [N-1:0]  tmr_clr_m;
    logic [CW-1:0] count_q;
    logic [N-1:0]  all_set;
    logic [N-1:0]  all_clr;
    stat_t         stat;

    irq_cmd_decode #(.N(N), .IW(IW)) u_dec (
        .op    (cmd_op_e'(cmd_op)),
        .idx   (cmd_line),
        .set_m (cmd_upd.set_m),
        .clr_m (cmd_upd.clr_m),
        .bad   (cmd_upd.bad)
    );

    irq_timer #(.N(N), .LW(LW), .CW(CW)) u_tmr (
        .clk       (clk),
        .rst       (rst),
        .cmp_we    (cmp_we),
        .cmp_wdata (cmp_wdata),
        .sel       (tmr_line),
        .hit       (tmr_hit),
        .hit_m     (tmr_set_m),
        .wclr_m    (tmr_clr_m),
        .count     (count_q)
    );

    assign all_set = cmd_upd.set_m | tmr_set_m;
    assign all_clr = cmd_upd.clr_m | tmr_clr_m;

    irq_pend_reg #(.N(N)) u_pend (
        .clk   (clk),
        .rst   (rst),
        .set_m (all_set),
        .clr_m (all_clr),
        .bad   (cmd_upd.bad),
        .pend  (pend_vec),
        .err   (cmd_err)
    );

    assign stat.mask = stat_mask;
    assign stat.gie  = stat_gie;
    assign stat.exl  = stat_exl;
    assign stat.erl  = stat_erl;

    irq_qualify u_qual (
        .stat (stat),
        .pend (pend_vec),
        .req  (irq_req),
        .any  (pend_any)
    );

endmodule

// File: rtl/irq_pend_chk.sv
module irq_pend_chk #(
    parameter int N  = 8,
    parameter int LW = 3,
    parameter int IW = 4,
    parameter int CW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic [1:0]    cmd_op,
    input logic [IW-1:0] cmd_line,
    input logic          stat_gie,
    input logic          stat_exl,
    input logic          stat_erl,
    input logic [LW-1:0] tmr_line,
    input logic          cmp_we,
    input logic [N-1:0]  pend_vec,
    input logic          pend_any,
    input logic          irq_req,
    input logic          cmd_err,
    input logic          tmr_hit,
    input logic [CW-1:0] count_q
);
    logic rst_d = 1'b0;
    logic post_ok;
    logic clr_ok;

    assign post_ok = (cmd_op == 2'd1) && (cmd_line < IW'(N));
    assign clr_ok  = (cmd_op == 2'd2) && (cmd_line < IW'(N));

    always_ff @(posedge clk) begin
        rst_d <= rst;
    end

    always_ff @(posedge clk) begin
        if (rst_d && !rst) begin
            AST_RESET_EMPTY: assert (pend_vec == '0 && !cmd_err); // R1
        end
    end

    AST_POST_SETS: assert property (@(posedge clk) disable iff (rst)
        post_ok |=> pend_vec[$past(cmd_line[LW-1:0])]); // R2

    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (rst)
        (clr_ok && !(tmr_hit && tmr_line == cmd_line[LW-1:0]))
        |=> !pend_vec[$past(cmd_line[LW-1:0])]); // R2

    AST_BAD_LINE_FLAG: assert property (@(posedge clk) disable iff (rst)
        ((cmd_op == 2'd1 || cmd_op == 2'd2) && cmd_line >= IW'(N)) |=> cmd_err); // R3

    AST_GATE_CLOSED: assert property (@(posedge clk) disable iff (rst)
        (!stat_gie || stat_exl || stat_erl) |-> !irq_req); // R4

    AST_ZERO_NO_MATCH: assert property (@(posedge clk) disable iff (rst)
        (count_q == '0) |-> !tmr_hit); // R6

    AST_TIMER_RAISE: assert property (@(posedge clk) disable iff (rst)
        tmr_hit |=> pend_vec[$past(tmr_line)]); // R7

    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        !pend_any |-> !irq_req); // R8

    AST_WRITE_ACK: assert property (@(posedge clk) disable iff (rst)
        (cmp_we && !tmr_hit && !(post_ok && cmd_line[LW-1:0] == tmr_line))
        |=> !pend_vec[$past(tmr_line)]); // R9

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (cmp_we && post_ok && cmd_line[LW-1:0] == tmr_line)
        |=> pend_vec[$past(tmr_line)]); // R10

endmodule

bind irq_pend_ctrl irq_pend_chk #(.N(N), .LW(LW), .IW(IW), .CW(CW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cmd_op   (cmd_op),
    .cmd_line (cmd_line),
    .stat_gie (stat_gie),
    .stat_exl (stat_exl),
    .stat_erl (stat_erl),
    .tmr_line (tmr_line),
    .cmp_we   (cmp_we),
    .pend_vec (pend_vec),
    .pend_any (pend_any),
    .irq_req  (irq_req),
    .cmd_err  (cmd_err),
    .tmr_hit  (tmr_hit),
    .count_q  (count_q)
);

// File: tb/irq_pend_ctrl_test.sv
`timescale 1ns/1ps
module irq_pend_ctrl_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cmd_op = 2'd0;
    logic [3:0]  cmd_line = 4'd0;
    logic [7:0]  stat_mask = 8'h00;
    logic        stat_gie = 1'b0;
    logic        stat_exl = 1'b0;
    logic        stat_erl = 1'b0;
    logic [2:0]  tmr_line = 3'd0;
    logic        cmp_we = 1'b0;
    logic [31:0] cmp_wdata = 32'd0;
    logic [7:0]  pend_vec;
    logic        pend_any;
    logic        irq_req;
    logic        cmd_err;

    int checks = 0;
    int fails  = 0;

    // behavioural reference state
    logic [7:0]  m_pend = 8'h00;
    logic        m_err  = 1'b0;
    logic [31:0] m_cnt  = 32'd0;
    logic [31:0] m_cmp  = 32'd0;

    always #4 clk = ~clk;

    irq_pend_ctrl uut (
        .clk       (clk),
        .rst       (rst),
        .cmd_op    (cmd_op),
        .cmd_line  (cmd_line),
        .stat_mask (stat_mask),
        .stat_gie  (stat_gie),
        .stat_exl  (stat_exl),
        .stat_erl  (stat_erl),
        .tmr_line  (tmr_line),
        .cmp_we    (cmp_we),
        .cmp_wdata (cmp_wdata),
        .pend_vec  (pend_vec),
        .pend_any  (pend_any),
        .irq_req   (irq_req),
        .cmd_err   (cmd_err)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // model update on each edge
    always @(posedge clk) begin
        if (rst) begin
            m_pend = 8'h00;
            m_err  = 1'b0;
            m_cnt  = 32'd0;
            m_cmp  = 32'd0;
        end else begin
            logic [7:0] s;
            logic [7:0] c;
            logic       b;
            s = 8'h00;
            c = 8'h00;
            b = 1'b0;
            if (cmd_op == 2'd1) begin
                if (cmd_line < 8) s[cmd_line[2:0]] = 1'b1; else b = 1'b1;
            end else if (cmd_op == 2'd2) begin
                if (cmd_line < 8) c[cmd_line[2:0]] = 1'b1; else b = 1'b1;
            end else if (cmd_op == 2'd3) begin
                c = 8'hFF;
            end
            if (m_cnt == m_cmp && m_cnt != 0) s[tmr_line] = 1'b1;
            if (cmp_we) c[tmr_line] = 1'b1;
            m_pend = (m_pend & ~c) | s;
            m_err  = b;
            m_cnt  = m_cnt + 1;
            if (cmp_we) m_cmp = cmp_wdata;
        end
    end

    // per-cycle comparison, away from the edges
    always @(negedge clk) begin
        #1;
        if (!rst) begin
            check("R2 pend_vec vs model", {24'd0, pend_vec}, {24'd0, m_pend});
            check("R3 cmd_err vs model", {31'd0, cmd_err}, {31'd0, m_err});
            check("R8 pend_any vs model", {31'd0, pend_any}, {31'd0, (m_pend != 0)});
            check("R4 irq_req vs model", {31'd0, irq_req},
                  {31'd0, stat_gie && !stat_exl && !stat_erl && ((stat_mask & m_pend) != 0)});
        end
    end

    task automatic do_cmd(input logic [1:0] op, input logic [3:0] line);
        @(negedge clk);
        cmd_op   = op;
        cmd_line = line;
        @(negedge clk);
        cmd_op   = 2'd0;
        #2;
    endtask

    task automatic write_cmp(input logic [31:0] v);
        @(negedge clk);
        cmp_we    = 1'b1;
        cmp_wdata = v;
        @(negedge clk);
        cmp_we    = 1'b0;
        #2;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] target;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        #2;
        // R1 and R6: compare and count both start at 0, no match
        check("R1 reset vector", {24'd0, pend_vec}, 32'h0);
        check("R1 reset err", {31'd0, cmd_err}, 32'h0);
        check("R6 zero count no match", {24'd0, pend_vec}, 32'h0);

        do_cmd(2'd1, 4'd0);
        do_cmd(2'd1, 4'd3);
        do_cmd(2'd1, 4'd7);
        check("R2 post lines 0,3,7", {24'd0, pend_vec}, 32'h89);

        stat_gie = 1'b1; stat_mask = 8'h08; #1;
        check("R5 mask bit3 matches", {31'd0, irq_req}, 32'h1);
        stat_mask = 8'h10; #1;
        check("R5 mask bit4 misses", {31'd0, irq_req}, 32'h0);
        check("R8 any despite mask", {31'd0, pend_any}, 32'h1);
        stat_mask = 8'hFF; stat_exl = 1'b1; #1;
        check("R4 exl blocks", {31'd0, irq_req}, 32'h0);
        stat_exl = 1'b0; stat_erl = 1'b1; #1;
        check("R4 erl blocks", {31'd0, irq_req}, 32'h0);
        stat_erl = 1'b0; stat_gie = 1'b0; #1;
        check("R4 gie off blocks", {31'd0, irq_req}, 32'h0);
        stat_gie = 1'b1; #1;
        check("R4 all open", {31'd0, irq_req}, 32'h1);

        do_cmd(2'd2, 4'd3);
        check("R2 clear line 3", {24'd0, pend_vec}, 32'h81);
        do_cmd(2'd1, 4'd9);
        check("R3 bad post err", {31'd0, cmd_err}, 32'h1);
        check("R3 bad post no change", {24'd0, pend_vec}, 32'h81);
        do_cmd(2'd2, 4'd12);
        check("R3 bad clear err", {31'd0, cmd_err}, 32'h1);
        check("R3 bad clear no change", {24'd0, pend_vec}, 32'h81);
        @(negedge clk); #2;
        check("R3 err one cycle", {31'd0, cmd_err}, 32'h0);

        do_cmd(2'd3, 4'd2);
        check("R2 clear-all", {24'd0, pend_vec}, 32'h0);
        check("R8 none pending", {31'd0, pend_any}, 32'h0);

        tmr_line = 3'd5;
        write_cmp(m_cnt + 32'd10);
        repeat (3) @(negedge clk); #2;
        check("R6 no early match", {24'd0, pend_vec}, 32'h0);
        repeat (10) @(negedge clk); #2;
        check("R7 timer raises line 5", {24'd0, pend_vec}, 32'h20);

        write_cmp(32'd0);
        check("R9 compare write acks", {24'd0, pend_vec}, 32'h0);

        @(negedge clk);
        cmd_op = 2'd1; cmd_line = 4'd5; cmp_we = 1'b1; cmp_wdata = 32'd0;
        @(negedge clk);
        cmd_op = 2'd0; cmp_we = 1'b0; #2;
        check("R10 post beats write ack", {24'd0, pend_vec}, 32'h20);
        do_cmd(2'd3, 4'd0);

        target = m_cnt + 32'd6;
        write_cmp(target);
        while (m_cnt != target) begin
            @(negedge clk); #2;
        end
        cmd_op = 2'd2; cmd_line = 4'd5;
        @(negedge clk);
        cmd_op = 2'd0; #2;
        check("R10 timer beats clear", {24'd0, pend_vec}, 32'h20);

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule